// File: doc/BRIEF.md
# Interrupt Trigger-Mode Configuration Bank

This block is a memory-mapped register bank that records, for every interrupt ID, whether the interrupt is level-sensitive or edge-triggered. Software reaches it with 32-bit word accesses over a simple valid/write/address/data port that answers every request with an ack one cycle later. Each word packs sixteen 2-bit fields, one per interrupt. Within a field the upper bit carries the trigger mode and the lower bit is reserved. The stored mode bits drive a per-interrupt edge/level vector that downstream pending logic consumes.

The first word covers the software-generated interrupts. It is fixed: every field reads as edge-triggered and writes have no effect. The second word covers the private peripheral interrupts, and each processing element (PE) has its own copy of it, selected by the requester's processor number. Which private interrupts software may reprogram is chosen at build time. The remaining words cover shared peripheral interrupts up to the implemented count.

Every access passes through a security filter. When security is enabled, a non-secure requester can neither see nor change the fields of interrupts whose group attribute marks them as secure-only.

Top module: `trig_cfg_bank`

## Requirements
- R1: Word n (0 to 63) sits at byte address BASE + 4·n, and BASE is aligned to the 256-byte window. The field of interrupt ID 16·n + x occupies bits [2x+1:2x] of word n. Code 2'b10 means edge-triggered and 2'b00 means level-sensitive. A write stores bit 2x+1 as the mode of that interrupt.
- R2: The low bit (2x) of every field reads as 0, and writing it has no effect.
- R3: Word 0 always reads 32'hAAAA_AAAA and ignores writes.
- R4: Word 1 is banked. A requester with processor number p < NUM_PE reads and writes only its own copy, and that copy drives ppi_edge_o[16·p + x] for interrupt ID 16 + x.
- R5: A requester with processor number ≥ NUM_PE reads word 1 as 0, and its writes to word 1 change no bank.
- R6: A private interrupt x whose bit in PPI_WR_MASK is 0 always reports PPI_FIXED_EDGE[x] and ignores writes. Writable private fields reset to level-sensitive.
- R7: Fields of interrupt IDs ≥ NUM_IRQ read as 0 and ignore writes.
- R8: When sec_disable_i is 0 and req_secure_i is 0, a field whose irq_ns_i bit (bit ID−16) is 0 reads as 0 and ignores writes. When either input is 1, all fields are accessible.
- R9: Every request with req_valid_i high is answered by rsp_ack_o high exactly in the next cycle, and rsp_ack_o is low otherwise. rsp_rdata_o carries the read data alongside the ack. Addresses outside the window, or not word-aligned, read as 0 and drop writes.
- R10: After reset every shared interrupt is level-sensitive (spi_edge_o all 0), and rsp_ack_o is 0.
- R11: spi_edge_o[i] is the stored mode of interrupt ID 32 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_pe_i | input | PE_W | Processor number of the requester |
| req_secure_i | input | 1 | 1 = secure access |
| sec_disable_i | input | 1 | 1 = security filter off |
| irq_ns_i | input | NUM_IRQ-16 | Bit k = 1 when interrupt ID 16+k is non-secure accessible |
| rsp_ack_o | output | 1 | Access completed, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, valid with the ack |
| spi_edge_o | output | NUM_IRQ-32 | Edge mode of shared interrupts, ID 32+i |
| ppi_edge_o | output | 16·NUM_PE | Edge mode of private interrupts per PE |

## Verification
The bench builds the block with NUM_IRQ = 72, NUM_PE = 3, PPI_WR_MASK = 16'h0F3C and PPI_FIXED_EDGE = 16'hA0C5. With these values word 4 is partly implemented, so implemented and unimplemented fields share one word. Processor number 3 lies just past the last bank, and private fields of both kinds sit side by side. These values keep the state small enough to sweep every window word for every requester, in both security states, after each write phase. The non-secure phases use a mixed group pattern, so the filter is exercised on individual fields rather than whole words.

// File: rtl/trig_cfg_pkg.sv
package trig_cfg_pkg;
  localparam int unsigned FIELDS = 16;
  localparam logic [31:0] SGI_WORD  = 32'hAAAA_AAAA;
  localparam logic [31:0] RES0_MASK = 32'h5555_5555;

  // place mode bits on odd positions, reserved bits stay zero
  function automatic logic [31:0] spread(input logic [FIELDS-1:0] e);
    logic [31:0] r;
    r = '0;
    for (int f = 0; f < FIELDS; f++) r[2*f+1] = e[f];
    return r;
  endfunction

  function automatic logic [FIELDS-1:0] gather(input logic [31:0] d);
    logic [FIELDS-1:0] r;
    for (int f = 0; f < FIELDS; f++) r[f] = d[2*f+1];
    return r;
  endfunction
endpackage

// File: rtl/trig_addr_dec.sv
module trig_addr_dec #(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       WORD_W = 6,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0C00
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned LO = WORD_W + 2;

  // BASE is aligned to the window size, so the word index is a plain slice
  assign in_win_o = (addr_i[ADDR_W-1:LO] == BASE[ADDR_W-1:LO]) && (addr_i[1:0] == 2'b00);
  assign word_o   = addr_i[LO-1:2];
endmodule

// File: rtl/trig_sec_mask.sv
module trig_sec_mask #(
  parameter int unsigned NUM_IRQ = 256,
  parameter int unsigned WORD_W  = 6
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic               sec_disable_i,
  input  logic               secure_i,
  input  logic [NUM_IRQ-17:0] irq_ns_i,
  output logic [15:0]        vis_o
);
  localparam int unsigned SLOTS = (2**WORD_W) * 16;

  logic [SLOTS-1:0] ns_pad;
  logic [SLOTS-1:0] impl_pad;
  logic             open_all;

  for (genvar j = 0; j < SLOTS; j++) begin : g_pad
    if (j >= 16 && j < NUM_IRQ) begin : g_ns
      assign ns_pad[j] = irq_ns_i[j-16];
    end else begin : g_nns
      assign ns_pad[j] = 1'b0;
    end
    assign impl_pad[j] = (j < NUM_IRQ);
  end

  assign open_all = sec_disable_i | secure_i;

  always_comb begin
    for (int f = 0; f < 16; f++) begin
      vis_o[f] = impl_pad[{word_i, 4'(f)}] & (open_all | ns_pad[{word_i, 4'(f)}]);
    end
  end
endmodule

// File: rtl/trig_ppi_bank.sv
module trig_ppi_bank #(
  parameter int unsigned NUM_PE     = 8,
  parameter int unsigned PE_W       = 4,
  parameter logic [15:0] WR_MASK    = 16'hFFFF,
  parameter logic [15:0] FIXED_EDGE = 16'h0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [PE_W-1:0]      pe_i,
  input  logic [15:0]          wmask_i,
  input  logic [15:0]          wedge_i,
  output logic                 pe_ok_o,
  output logic [15:0]          rd_edge_o,
  output logic [NUM_PE*16-1:0] edge_o
);
  assign pe_ok_o = ({1'b0, pe_i} < (PE_W+1)'(NUM_PE));

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    logic [15:0] q;
    logic [15:0] m;
    assign m = (we_i && pe_i == PE_W'(p)) ? (wmask_i & WR_MASK) : 16'h0000;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= (q & ~m) | (wedge_i & m);
    end
    assign edge_o[p*16 +: 16] = (q & WR_MASK) | (FIXED_EDGE & ~WR_MASK);
  end

  always_comb begin
    rd_edge_o = '0;
    for (int p = 0; p < NUM_PE; p++) begin
      if (pe_i == PE_W'(p)) rd_edge_o = edge_o[p*16 +: 16];
    end
  end
endmodule

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
  import trig_cfg_pkg::*;
#(
  parameter int unsigned       NUM_IRQ        = 256,
  parameter int unsigned       NUM_PE         = 8,
  parameter int unsigned       PE_W           = 4,
  parameter int unsigned       ADDR_W         = 16,
  parameter int unsigned       WORD_W         = 6,
  parameter logic [ADDR_W-1:0] BASE           = 16'h0C00,
  parameter logic [15:0]       PPI_WR_MASK    = 16'hFFFF,
  parameter logic [15:0]       PPI_FIXED_EDGE = 16'h0000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [31:0]           req_wdata_i,
  input  logic [PE_W-1:0]       req_pe_i,
  input  logic                  req_secure_i,
  input  logic                  sec_disable_i,
  input  logic [NUM_IRQ-17:0]   irq_ns_i,
  output logic                  rsp_ack_o,
  output logic [31:0]           rsp_rdata_o,
  output logic [NUM_IRQ-33:0]   spi_edge_o,
  output logic [NUM_PE*16-1:0]  ppi_edge_o
);
  localparam int unsigned NUM_SPI = NUM_IRQ - 32;
  localparam int unsigned SLOTS   = (2**WORD_W) * 16;

  logic              in_win;
  logic [WORD_W-1:0] word;
  logic [15:0]       vis;
  logic              is_sgi, is_ppi, pe_ok, wr_go;
  logic [15:0]       ppi_rd, wedge, vis_eff, wmask, word_edge;
  logic [31:0]       rd_val;
  logic              unused_res0;

  trig_addr_dec #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BASE(BASE)
  ) i_dec (
    .addr_i  (req_addr_i),
    .in_win_o(in_win),
    .word_o  (word)
  );

  trig_sec_mask #(
    .NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W)
  ) i_sec (
    .word_i       (word),
    .sec_disable_i(sec_disable_i),
    .secure_i     (req_secure_i),
    .irq_ns_i     (irq_ns_i),
    .vis_o        (vis)
  );

  assign is_sgi      = (word == WORD_W'(0));
  assign is_ppi      = (word == WORD_W'(1));
  assign wr_go       = req_valid_i & req_write_i & in_win;
  assign wedge       = gather(req_wdata_i);
  assign unused_res0 = ^(req_wdata_i & RES0_MASK);

  trig_ppi_bank #(
    .NUM_PE(NUM_PE), .PE_W(PE_W), .WR_MASK(PPI_WR_MASK), .FIXED_EDGE(PPI_FIXED_EDGE)
  ) i_ppi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_go & is_ppi),
    .pe_i     (req_pe_i),
    .wmask_i  (wmask),
    .wedge_i  (wedge),
    .pe_ok_o  (pe_ok),
    .rd_edge_o(ppi_rd),
    .edge_o   (ppi_edge_o)
  );

  // shared interrupt storage, one mode bit per implemented ID
  logic [NUM_SPI-1:0] spi_q, spi_we, spi_d;
  logic [SLOTS-1:0]   spi_pad;

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_spi
    localparam int unsigned ID = i + 32;
    assign spi_we[i] = wr_go && (word == WORD_W'(ID / 16)) && wmask[ID % 16];
    assign spi_d[i]  = wedge[ID % 16];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spi_q <= '0;
    else         spi_q <= (spi_q & ~spi_we) | (spi_d & spi_we);
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_pad
    if (j >= 32 && j < NUM_IRQ) begin : g_on
      assign spi_pad[j] = spi_q[j-32];
    end else begin : g_off
      assign spi_pad[j] = 1'b0;
    end
  end

  always_comb begin
    if (is_sgi) begin
      word_edge = 16'hFFFF;
      vis_eff   = 16'hFFFF;
      wmask     = 16'h0000;
    end else if (is_ppi) begin
      word_edge = ppi_rd;
      vis_eff   = pe_ok ? vis : 16'h0000;
      wmask     = vis_eff & PPI_WR_MASK;
    end else begin
      word_edge = spi_pad[{word, 4'h0} +: 16];
      vis_eff   = vis;
      wmask     = vis;
    end
  end

  assign rd_val = spread(word_edge & vis_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_ack_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_ack_o   <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i && in_win) ? rd_val : 32'h0;
    end
  end

  assign spi_edge_o = spi_q;
endmodule

// File: rtl/trig_cfg_bank_chk.sv
module trig_cfg_bank_chk #(
  parameter int unsigned       NUM_IRQ = 256,
  parameter int unsigned       NUM_PE  = 8,
  parameter int unsigned       PE_W    = 4,
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       WORD_W  = 6,
  parameter logic [ADDR_W-1:0] BASE    = 16'h0C00
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_write_i,
  input logic [ADDR_W-1:0]    req_addr_i,
  input logic [PE_W-1:0]      req_pe_i,
  input logic                 req_secure_i,
  input logic                 sec_disable_i,
  input logic [NUM_IRQ-17:0]  irq_ns_i,
  input logic                 rsp_ack_o,
  input logic [31:0]          rsp_rdata_o,
  input logic [NUM_IRQ-33:0]  spi_edge_o,
  input logic [NUM_PE*16-1:0] ppi_edge_o
);
  logic        rd_req, win, pe_high;
  logic [31:0] a32;

  assign a32     = 32'(req_addr_i);
  assign rd_req  = req_valid_i && !req_write_i;
  assign win     = (a32 >= 32'(BASE)) && (a32 < 32'(BASE) + 32'((2**WORD_W) * 4)) && (a32 % 4 == 0);
  assign pe_high = 32'(req_pe_i) >= NUM_PE;

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_ack_o); // R9
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_ack_o); // R9
  AST_RES0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ack_o |-> ((rsp_rdata_o & 32'h5555_5555) == 32'h0)); // R2
  AST_SGI_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && a32 == 32'(BASE)) |=> (rsp_rdata_o == 32'hAAAA_AAAA)); // R3
  AST_OUT_WIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !win) |=> (rsp_rdata_o == 32'h0)); // R9
  AST_PE_HIGH_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && a32 == 32'(BASE) + 32'd4 && pe_high) |=> (rsp_rdata_o == 32'h0)); // R5
  AST_PE_HIGH_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_high |=> $stable(ppi_edge_o)); // R5
  AST_NS_SPI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_secure_i && !sec_disable_i) |=>
    (((spi_edge_o ^ $past(spi_edge_o)) & ~$past(irq_ns_i[NUM_IRQ-17:16])) == '0)); // R8

  for (genvar p = 0; p < NUM_PE; p++) begin : g_iso
    AST_BANK_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_pe_i != PE_W'(p)) |=> $stable(ppi_edge_o[p*16 +: 16])); // R4
  end
endmodule

bind trig_cfg_bank trig_cfg_bank_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE), .PE_W(PE_W),
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BASE(BASE)
) i_trig_cfg_bank_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_addr_i   (req_addr_i),
  .req_pe_i     (req_pe_i),
  .req_secure_i (req_secure_i),
  .sec_disable_i(sec_disable_i),
  .irq_ns_i     (irq_ns_i),
  .rsp_ack_o    (rsp_ack_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .spi_edge_o   (spi_edge_o),
  .ppi_edge_o   (ppi_edge_o)
);

// File: tb/test_trig_cfg_bank.sv
`timescale 1ns/1ps
module test_trig_cfg_bank;
  localparam int unsigned NUM_IRQ = 72;
  localparam int unsigned NUM_PE  = 3;
  localparam int unsigned PE_W    = 4;
  localparam int unsigned NUM_SPI = NUM_IRQ - 32;
  localparam logic [15:0] BASE    = 16'h0C00;
  localparam logic [15:0] WR_M    = 16'h0F3C;
  localparam logic [15:0] FIX_E   = 16'hA0C5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b1, sec_dis = 1'b1;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [PE_W-1:0] req_pe = '0;
  logic [NUM_IRQ-17:0] ns_r = '0;
  logic rsp_ack;
  logic [31:0] rsp_rdata;
  logic [NUM_SPI-1:0] spi_edge;
  logic [NUM_PE*16-1:0] ppi_edge;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [NUM_SPI-1:0] spi_m;
  logic [15:0] ppi_m [NUM_PE];

  always #2 clk = ~clk;

  trig_cfg_bank #(
    .NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE), .PE_W(PE_W), .ADDR_W(16), .WORD_W(6),
    .BASE(BASE), .PPI_WR_MASK(WR_M), .PPI_FIXED_EDGE(FIX_E)
  ) i_trig_cfg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_pe_i(req_pe),
    .req_secure_i(req_secure), .sec_disable_i(sec_dis), .irq_ns_i(ns_r),
    .rsp_ack_o(rsp_ack), .rsp_rdata_o(rsp_rdata), .spi_edge_o(spi_edge), .ppi_edge_o(ppi_edge)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return (a >= BASE) && (a < BASE + 16'd256) && (a[1:0] == 2'b00);
  endfunction

  function automatic bit perm(input int id, input bit s);
    if (id < 16 || id >= NUM_IRQ) return 1'b0;
    return sec_dis | s | ns_r[id-16];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [15:0] a, input int pe, input bit s);
    logic [31:0] r;
    int w;
    r = '0;
    if (!in_win(a)) return r;
    w = int'((a - BASE) >> 2);
    if (w == 0) return 32'hAAAA_AAAA;
    for (int f = 0; f < 16; f++) begin
      int id;
      id = w * 16 + f;
      if (w == 1) begin
        if (pe < NUM_PE && perm(id, s)) r[2*f+1] = ppi_m[pe][f];
      end else if (id < NUM_IRQ && perm(id, s)) begin
        r[2*f+1] = spi_m[id-32];
      end
    end
    return r;
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [31:0] d, input int pe, input bit s);
    int w;
    if (!in_win(a)) return;
    w = int'((a - BASE) >> 2);
    if (w == 0) return;
    for (int f = 0; f < 16; f++) begin
      int id;
      id = w * 16 + f;
      if (w == 1) begin
        if (pe < NUM_PE && WR_M[f] && perm(id, s)) ppi_m[pe][f] = d[2*f+1];
      end else if (id < NUM_IRQ && perm(id, s)) begin
        spi_m[id-32] = d[2*f+1];
      end
    end
  endtask

  function automatic string tag_rd(input logic [15:0] a, input int pe, input bit s);
    int w;
    if (!in_win(a)) return "R9";
    w = int'((a - BASE) >> 2);
    if (w == 0) return "R3";
    if (w == 1 && pe >= NUM_PE) return "R5";
    if (!sec_dis && !s) return "R8";
    if (w * 16 + 15 >= NUM_IRQ) return "R7";
    if (w == 1) return "R4";
    return "R1";
  endfunction

  // inputs change 1 ns after a rising edge; results sampled 1 ns after the next
  task automatic acc(input bit wr, input logic [15:0] a, input logic [31:0] d, input int pe, input bit s);
    logic [31:0] e;
    e = exp_rd(a, pe, s);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_pe = PE_W'(pe); req_secure = s;
    @(posedge clk); #1;
    chk("R9", 64'(rsp_ack), 64'd1, "ack after request");
    if (!wr) begin
      chk(tag_rd(a, pe, s), 64'(rsp_rdata), 64'(e), $sformatf("read %h pe %0d sec %0d", a, pe, s));
      chk("R2", 64'(rsp_rdata & 32'h5555_5555), 64'd0, "reserved bits");
    end
    req_valid = 1'b0;
    if (wr) model_wr(a, d, pe, s);
  endtask

  task automatic chk_out();
    chk("R11", 64'(spi_edge), 64'(spi_m), "spi_edge_o");
    for (int p = 0; p < NUM_PE; p++)
      chk("R4 R6", 64'(ppi_edge[p*16 +: 16]), 64'(ppi_m[p]), $sformatf("ppi_edge_o pe %0d", p));
  endtask

  task automatic sweep();
    for (int w = 0; w < 64; w++)
      for (int pe = 0; pe <= NUM_PE; pe++)
        for (int s = 0; s < 2; s++)
          acc(1'b0, BASE + 16'(4 * w), 32'h0, pe, s[0]);
  endtask

  task automatic wr_all(input logic [31:0] seed, input bit s);
    for (int pe = 0; pe <= NUM_PE; pe++)
      for (int w = 0; w < 64; w++)
        acc(1'b1, BASE + 16'(4 * w), seed ^ (32'(pe) * 32'h1357_9BDF) ^ (32'(w) * 32'h0F0F_3C3C), pe, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    spi_m = '0;
    for (int p = 0; p < NUM_PE; p++) ppi_m[p] = FIX_E & ~WR_M;
    #1;
    chk("R10", 64'(spi_edge), 64'd0, "spi_edge_o in reset");
    chk("R10", 64'(rsp_ack), 64'd0, "ack in reset");
    for (int p = 0; p < NUM_PE; p++)
      chk("R6", 64'(ppi_edge[p*16 +: 16]), 64'(16'hA0C1), $sformatf("ppi reset pe %0d", p));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R9", 64'(rsp_ack), 64'd0, "idle ack");

    sweep();
    wr_all(32'hFFFF_FFFF, 1'b1);
    chk_out();
    sweep();
    wr_all(32'h5555_5555, 1'b1);
    chk_out();
    wr_all(32'hA5C3_96F0, 1'b1);
    chk_out();

    sec_dis = 1'b0;
    ns_r = 56'hA5_3C69_0F96_C3F0;
    sweep();
    wr_all(32'h0000_0000, 1'b0);
    chk_out();
    sweep();
    ns_r = ~ns_r;
    wr_all(32'hFFFF_FFFF, 1'b0);
    chk_out();
    sweep();
    wr_all(32'h3CA5_5AC3, 1'b1);
    chk_out();

    sec_dis = 1'b1;
    acc(1'b1, BASE - 16'd4, 32'h0, 0, 1'b1);
    acc(1'b1, BASE + 16'd256, 32'h0, 0, 1'b1);
    acc(1'b1, BASE + 16'd10, 32'h0, 0, 1'b1);
    acc(1'b1, BASE + 16'd9, 32'h0, 1, 1'b1);
    acc(1'b1, 16'hFFFC, 32'h0, 2, 1'b1);
    chk_out();
    acc(1'b0, BASE - 16'd4, 32'h0, 0, 1'b1);
    acc(1'b0, BASE + 16'd256, 32'h0, 0, 1'b1);
    acc(1'b0, BASE + 16'd10, 32'h0, 0, 1'b1);
    acc(1'b0, 16'h0000, 32'h0, 0, 1'b1);
    sweep();
    chk_out();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule